// File: doc/BRIEF.md
# Instruction-Addressed General Register Bank

This block holds the general registers of a single-bus processor: sixteen words of 32 bits behind one shared read/write port. The register number is not supplied as an address. Instead, a 2-bit field-select code picks one of three fixed 4-bit slices of the current instruction word.

When the write enable is high, the value on the bus input is written into the chosen register at the rising clock edge. When the drive enable is high, the chosen register's contents appear on the bus output. When the drive enable is low, the output is held at zero, so it can be OR-combined with other bus sources.

Register 0 is a constant zero. The fourth select code is a safe default that points at register 0. A synchronous, active-high reset clears the whole bank.

Top module: `gpr_bank`

## Requirements
- R1: The bank stores 16 independent 32-bit words. A value written to any register from 1 to 15 reads back unchanged until that register is written again or reset.
- R2: Select code 2'b00 addresses the register whose number is in instruction bits [27:24].
- R3: Select code 2'b01 addresses the register whose number is in instruction bits [23:20].
- R4: Select code 2'b10 addresses the register whose number is in instruction bits [3:0].
- R5: Select code 2'b11 addresses register 0 and raises no error. Reads under it return zero, and writes under it change no register.
- R6: Register 0 always reads as zero. A write to it, including a write of a nonzero value, has no effect.
- R7: With `wr_en` high, `bus_in` is stored into the addressed register on the rising clock edge. With `wr_en` low, no register changes.
- R8: With `drv_en` high, `bus_out` equals the addressed register's contents. With `drv_en` low, `bus_out` is zero.
- R9: A read of the register being written in the same cycle returns the old value. The new value is visible from the cycle after the edge.
- R10: While `rst` is high at a rising clock edge, registers 1 to 15 are cleared to zero. Reset takes priority over a simultaneous write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ir_word | input | 32 | Current instruction word supplying the register-number fields |
| sel_code | input | 2 | Field select: 00 bits[27:24], 01 bits[23:20], 10 bits[3:0], 11 register 0 |
| wr_en | input | 1 | Write the bus value into the addressed register at the clock edge |
| drv_en | input | 1 | Present the addressed register on the bus output |
| bus_in | input | 32 | Value from the shared bus to be written |
| bus_out | output | 32 | Addressed register contents when driving, zero otherwise |

## Verification
The assertions check four behaviours on every cycle:
- the output is zero whenever the drive enable is low;
- an access resolving to register 0 yields zero;
- a value written in one cycle is read back in the next through the same register number;
- a driven register that is not written holds its value.

They also check that the cycle after a reset reads zero. Other properties need the bench's scenarios:
- whether each select code really takes its own instruction slice;
- whether every one of the sixteen locations is independent storage;
- that a discarded write through code 11 left every other register untouched;
- that reset wins over a simultaneous write.

The bench uses full sweeps across all registers and all select codes, with a reference array.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
    localparam int NUM_REGS = 16;
    localparam int DATA_W   = 32;
    localparam int IR_W     = 32;
    localparam int IDX_W    = $clog2(NUM_REGS);

    // Bit positions of the three register-number slices in the instruction
    localparam int FLD_A_LSB = 24;
    localparam int FLD_B_LSB = 20;
    localparam int FLD_C_LSB = 0;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [1:0] {
        SEL_FLD_A = 2'b00,
        SEL_FLD_B = 2'b01,
        SEL_FLD_C = 2'b10,
        SEL_NONE  = 2'b11
    } sel_e;

    typedef struct packed {
        logic  we;
        idx_t  idx;
        word_t data;
    } wr_req_t;

    function automatic idx_t slice_at(input logic [IR_W-1:0] ir, input int lsb);
        return ir[lsb +: IDX_W];
    endfunction
endpackage

// File: rtl/gpr_field_sel.sv
module gpr_field_sel
    import gpr_pkg::*;
(
    input  logic [IR_W-1:0] ir_word,
    input  logic [1:0]      sel_code,
    output idx_t            idx
);
    sel_e sel;
    idx_t fld_a, fld_b, fld_c;
    logic unused_ir_bits;

    assign sel   = sel_e'(sel_code);
    assign fld_a = ir_word[FLD_A_LSB +: IDX_W];
    assign fld_b = ir_word[FLD_B_LSB +: IDX_W];
    assign fld_c = ir_word[FLD_C_LSB +: IDX_W];
    assign unused_ir_bits = ^{ir_word[IR_W-1:FLD_A_LSB+IDX_W],
                              ir_word[FLD_B_LSB-1:FLD_C_LSB+IDX_W]};

    always_comb begin
        unique case (sel)
            SEL_FLD_A: idx = fld_a;
            SEL_FLD_B: idx = fld_b;
            SEL_FLD_C: idx = fld_c;
            default:   idx = '0;
        endcase
    end
endmodule

// File: rtl/gpr_storage.sv
module gpr_storage
    import gpr_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  wr_req_t                        req,
    output logic [NUM_REGS-1:0][DATA_W-1:0] regs
);
    // Location 0 is a constant; no flops behind it
    assign regs[0] = '0;

    for (genvar i = 1; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (req.we && (req.idx == idx_t'(i)))
                regs[i] <= req.data;
        end
    end
endmodule

// File: rtl/gpr_read_drive.sv
module gpr_read_drive
    import gpr_pkg::*;
(
    input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
    input  idx_t                            idx,
    input  logic                            drv_en,
    output word_t                           bus_out
);
    word_t picked;

    assign picked  = regs[idx];
    assign bus_out = drv_en ? picked : '0;
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
    import gpr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IR_W-1:0]   ir_word,
    input  logic [1:0]        sel_code,
    input  logic              wr_en,
    input  logic              drv_en,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out
);
    idx_t                            idx;
    wr_req_t                         req;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;

    gpr_field_sel u_sel (
        .ir_word (ir_word),
        .sel_code(sel_code),
        .idx     (idx)
    );

    assign req.we   = wr_en;
    assign req.idx  = idx;
    assign req.data = bus_in;

    gpr_storage u_store (
        .clk (clk),
        .rst (rst),
        .req (req),
        .regs(regs)
    );

    gpr_read_drive u_drive (
        .regs   (regs),
        .idx    (idx),
        .drv_en (drv_en),
        .bus_out(bus_out)
    );
endmodule

// File: rtl/gpr_bank_chk.sv
module gpr_bank_chk
    import gpr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [IR_W-1:0]   ir_word,
    input logic [1:0]        sel_code,
    input logic              wr_en,
    input logic              drv_en,
    input logic [DATA_W-1:0] bus_in,
    input logic [DATA_W-1:0] bus_out
);
    idx_t ref_idx;

    always_comb begin
        if (sel_code == 2'd0)      ref_idx = slice_at(ir_word, FLD_A_LSB);
        else if (sel_code == 2'd1) ref_idx = slice_at(ir_word, FLD_B_LSB);
        else if (sel_code == 2'd2) ref_idx = slice_at(ir_word, FLD_C_LSB);
        else                       ref_idx = '0;
    end

    // R8
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !drv_en |-> bus_out == '0);

    // R6
    reg0_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (drv_en && ref_idx == '0) |-> bus_out == '0);

    // R9
    write_visible_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst) && drv_en && ref_idx != '0 && ref_idx == $past(ref_idx))
            |-> bus_out == $past(bus_in));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (drv_en && $past(drv_en) && !$past(wr_en) && !$past(rst) && ref_idx == $past(ref_idx))
            |-> bus_out == $past(bus_out));

    // R10
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && drv_en) |-> bus_out == '0);
endmodule

bind gpr_bank gpr_bank_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .ir_word (ir_word),
    .sel_code(sel_code),
    .wr_en   (wr_en),
    .drv_en  (drv_en),
    .bus_in  (bus_in),
    .bus_out (bus_out)
);

// File: tb/gpr_bank_test.sv
module gpr_bank_test;
    logic        clk = 0;
    logic        rst = 1;
    logic [31:0] ir_word = '0;
    logic [1:0]  sel_code = '0;
    logic        wr_en = 0;
    logic        drv_en = 0;
    logic [31:0] bus_in = '0;
    logic [31:0] bus_out;

    int checks = 0;
    int fails  = 0;
    logic [31:0] mdl [16];

    always #5 clk = ~clk;

    gpr_bank uut (
        .clk(clk), .rst(rst), .ir_word(ir_word), .sel_code(sel_code),
        .wr_en(wr_en), .drv_en(drv_en), .bus_in(bus_in), .bus_out(bus_out)
    );

    function automatic logic [31:0] mk_ir(input int a, input int b, input int c);
        return {4'h9, a[3:0], b[3:0], 16'h5A5A, c[3:0]};
    endfunction

    // Fields filled so that each select code points at register r
    function automatic logic [31:0] ir_for(input int s, input int r);
        if (s == 0) return mk_ir(r, (r + 5) % 16, (r + 9) % 16);
        if (s == 1) return mk_ir((r + 3) % 16, r, (r + 7) % 16);
        return mk_ir((r + 11) % 16, (r + 2) % 16, r);
    endfunction

    task automatic chk(input logic [31:0] exp, input string tag);
        checks++;
        if (bus_out !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, bus_out, exp);
        end
    endtask

    task automatic rd(input logic [31:0] ir, input logic [1:0] s, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rst = 0; wr_en = 0; drv_en = 1; ir_word = ir; sel_code = s;
        #1 chk(exp, tag);
    endtask

    task automatic wr(input logic [31:0] ir, input logic [1:0] s, input logic [31:0] d, input int r);
        @(negedge clk);
        rst = 0; wr_en = 1; drv_en = 0; ir_word = ir; sel_code = s; bus_in = d;
        if (r > 0) mdl[r] = d;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        repeat (2) @(posedge clk);

        // R10: every register reads zero after reset
        for (int r = 0; r < 16; r++) rd(ir_for(0, r), 2'd0, 32'h0, "R10 post-reset");

        // R8: output is zero with drive low
        wr(ir_for(0, 4), 2'd0, 32'hDEAD_BEEF, 4);
        @(negedge clk);
        wr_en = 0; drv_en = 0;
        #1 chk(32'h0, "R8 idle bus");

        // R1 R2 R3 R4 R6 R7: write with one code, read with another
        for (int s = 0; s < 3; s++) begin
            for (int r = 0; r < 16; r++) begin
                logic [31:0] v;
                v = 32'hA500_0001 ^ (s << 16) ^ (r * 32'h0101_0101);
                wr(ir_for(s, r), s[1:0], v, r);
            end
            for (int r = 0; r < 16; r++) begin
                int s2;
                s2 = (s + 1) % 3;
                rd(ir_for(s2, r), s2[1:0], mdl[r], r == 0 ? "R6 reg0 read" : "R1 R2 R3 R4 readback");
            end
        end

        // R7: wr_en low leaves register unchanged
        @(negedge clk);
        wr_en = 0; drv_en = 0; ir_word = ir_for(2, 7); sel_code = 2'd2; bus_in = 32'h1234_5678;
        rd(ir_for(0, 7), 2'd0, mdl[7], "R7 no write when disabled");

        // R5: select 11 reads zero, write through it changes nothing
        rd(mk_ir(6, 7, 8), 2'd3, 32'h0, "R5 read code 11");
        wr(mk_ir(6, 7, 8), 2'd3, 32'hFFFF_FFFF, 0);
        for (int r = 0; r < 16; r++) rd(ir_for(1, r), 2'd1, mdl[r], "R5 no side effect");

        // R6: nonzero write to register 0
        wr(ir_for(2, 0), 2'd2, 32'h8000_0001, 0);
        rd(ir_for(0, 0), 2'd0, 32'h0, "R6 reg0 write discarded");

        // R9: read during write returns old value, new one after the edge
        @(negedge clk);
        wr_en = 1; drv_en = 1; ir_word = ir_for(0, 9); sel_code = 2'd0; bus_in = 32'h0BAD_F00D;
        #1 chk(mdl[9], "R9 old value same cycle");
        mdl[9] = 32'h0BAD_F00D;
        rd(ir_for(0, 9), 2'd0, mdl[9], "R9 new value next cycle");

        // R10: reset beats simultaneous write
        @(negedge clk);
        rst = 1; wr_en = 1; drv_en = 0; ir_word = ir_for(0, 5); sel_code = 2'd0; bus_in = 32'h7777_7777;
        @(negedge clk);
        rst = 0; wr_en = 0;
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        for (int r = 0; r < 16; r++) rd(ir_for(2, r), 2'd2, 32'h0, "R10 reset over write");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule